// File: doc/BRIEF.md
# DDR3 Reset Initialization Sequencer

This block sits on the controller side of a DDR3 SDRAM interface and brings the memory out of reset while the supply is already stable. It drives the active-low device reset, clock enable and on-die-termination pins. It also drives a plain command/address bus carrying chip select, the three command strobes, a 3-bit bank address and a row address. From reset release to the ready flag, every output change comes from one state machine and one shared down-counter.

All waits are given as nanosecond or clock-count parameters and turned into cycle counts from a clock-period parameter. Once the stabilisation waits are over, the block writes the four mode registers and then starts long ZQ calibration. The mode registers are written in the fixed order bank 2, bank 3, bank 1, bank 0, each with the full payload word taken from its input port. After the calibration time it raises `init_done` and leaves the bus deselected. A synchronous `restart` input runs the whole procedure again from the reset phase.

The termination pin level is chosen once, at the end of the reset phase, and is then held without change. It is driven low when the nominal-termination field in the MR1 payload is non-zero. Otherwise it takes a parameter-selected level.

Top module: `ddr3_rst_seq`

## Requirements
- R1: While `rst` is high, `ddr_reset_n`=0, `ddr_cke`=0, `ddr_cs_n`=1 and `init_done`=0.
- R2: After `rst` falls (or a restart is taken), `ddr_reset_n` stays low for exactly RST cycles, where RST is the larger of ceil(RESET_NS*1000/CLK_PS) and ceil(CKE_SU_NS*1000/CLK_PS). `ddr_cke` is low in every cycle in which `ddr_reset_n` is low.
- R3: `ddr_cke` rises exactly STAB = ceil(STAB_NS*1000/CLK_PS) cycles after `ddr_reset_n` rises.
- R4: The first mode-register write appears exactly XPR cycles after `ddr_cke` rises, where XPR is the larger of ceil(XPR_NS*1000/CLK_PS) and 5.
- R5: A mode-register write is cs_n=0, ras_n=0, cas_n=0, we_n=0. Four are issued per run, with `ddr_ba` = 2, 3, 1, 0 in that order and `ddr_addr` equal to the full `mr2`, `mr3`, `mr1`, `mr0` port value respectively.
- R6: Consecutive mode-register writes are exactly MRD_CYC cycles apart.
- R7: Calibration is cs_n=0, ras_n=1, cas_n=1, we_n=0, `ddr_ba`=0, `ddr_addr` with only bit 10 set. It is issued exactly MOD_CYC cycles after the bank-0 write.
- R8: `init_done` rises exactly ZQINIT_CYC cycles after the calibration command. It then stays high with `ddr_cs_n`=1 until a restart or reset.
- R9: Exactly five commands (cs_n=0) are issued per run; every other cycle carries cs_n=1.
- R10: `ddr_odt` is 0 if any of bits 2, 6, 9 of `mr1` is set, else ODT_IDLE. It holds one constant value from the rise of `ddr_reset_n` onward.
- R11: `restart` high at a clock edge re-enters the reset phase. At the next edge `ddr_reset_n`=0 and `init_done`=0, and the full sequence then repeats from R2, including from the middle of the mode-register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous request to rerun initialization |
| mr0 | input | ADDR_W | Payload for mode register 0 |
| mr1 | input | ADDR_W | Payload for mode register 1 (also selects ODT level) |
| mr2 | input | ADDR_W | Payload for mode register 2 |
| mr3 | input | ADDR_W | Payload for mode register 3 |
| ddr_reset_n | output | 1 | Device reset, active low |
| ddr_cke | output | 1 | Device clock enable |
| ddr_odt | output | 1 | On-die termination control, static |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank address |
| ddr_addr | output | ADDR_W | Row address / mode payload |
| init_done | output | 1 | Initialization complete |

## Verification
Several properties hold on every cycle and are checked by the assertions: clock enable never high while reset is asserted, the lower bounds on time before reset release and before clock-enable rise, the minimum spacing between mode writes and before calibration, the bit-10 flag on calibration, termination stability, and the rule that the ready flag drops only with reset re-entry. Other behaviour can be shown only by the directed scenarios. These cover the exact cycle counts of each phase, the bank order and full payload values, the count of five commands, the termination level for different MR1 fields, and a restart that arrives in the middle of the mode writes and then replays the whole sequence.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_STAB = 3'd1,
    ST_XPR  = 3'd2,
    ST_MRS  = 3'd3,
    ST_ZQ   = 3'd4,
    ST_DONE = 3'd5
  } init_st_e;

  typedef enum logic [1:0] {
    CMD_DES  = 2'd0,
    CMD_MRS  = 2'd1,
    CMD_ZQCL = 2'd2
  } init_cmd_e;

  localparam int ZQ_ADDR_BIT = 10;

  // Round a nanosecond time up to whole clock cycles.
  function automatic int ns_to_cyc(input longint ns, input longint clk_ps);
    longint c;
    c = (ns * longint'(1000) + clk_ps - longint'(1)) / clk_ps;
    return int'(c);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Write slot to mode-register number: fixed order 2, 3, 1, 0.
  function automatic logic [1:0] slot_to_mr(input logic [1:0] slot);
    case (slot)
      2'd0:    return 2'd2;
      2'd1:    return 2'd3;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R2
  tmr_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(cnt_q) == '0) |-> cnt_q == '0);

endmodule

// File: rtl/ddr3_init_fsm.sv
module ddr3_init_fsm
  import ddr3_init_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int RST_CYC    = 1,
  parameter int STAB_CYC   = 1,
  parameter int XPR_CYC    = 5,
  parameter int MRD_CYC    = 4,
  parameter int MOD_CYC    = 12,
  parameter int ZQINIT_CYC = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tmr_zero,
  output init_st_e         state,
  output logic [1:0]       slot,
  output logic             first,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  localparam logic [CNT_W-1:0] LV_RST  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] LV_STAB = CNT_W'(STAB_CYC - 1);
  localparam logic [CNT_W-1:0] LV_XPR  = CNT_W'(XPR_CYC - 1);
  localparam logic [CNT_W-1:0] LV_MRD  = CNT_W'(MRD_CYC - 1);
  localparam logic [CNT_W-1:0] LV_MOD  = CNT_W'(MOD_CYC - 1);
  localparam logic [CNT_W-1:0] LV_ZQ   = CNT_W'(ZQINIT_CYC - 1);

  init_st_e   st_q, st_d;
  logic [1:0] slot_q, slot_d;
  logic       first_q;

  always_comb begin
    st_d     = st_q;
    slot_d   = slot_q;
    load     = 1'b0;
    load_val = '0;
    if (restart) begin
      st_d     = ST_RST;
      slot_d   = 2'd0;
      load     = 1'b1;
      load_val = LV_RST;
    end else if (tmr_zero) begin
      case (st_q)
        ST_RST: begin
          st_d     = ST_STAB;
          load     = 1'b1;
          load_val = LV_STAB;
        end
        ST_STAB: begin
          st_d     = ST_XPR;
          load     = 1'b1;
          load_val = LV_XPR;
        end
        ST_XPR: begin
          st_d     = ST_MRS;
          slot_d   = 2'd0;
          load     = 1'b1;
          load_val = LV_MRD;
        end
        ST_MRS: begin
          load = 1'b1;
          if (slot_q == 2'd3) begin
            st_d     = ST_ZQ;
            load_val = LV_ZQ;
          end else begin
            slot_d   = slot_q + 2'd1;
            // the final write is followed by the longer mode-update gap
            load_val = (slot_q == 2'd2) ? LV_MOD : LV_MRD;
          end
        end
        ST_ZQ: begin
          st_d = ST_DONE;
          load = 1'b1;
        end
        default: begin
          st_d = ST_DONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RST;
      slot_q  <= 2'd0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      first_q <= load;
    end
  end

  assign state = st_q;
  assign slot  = slot_q;
  assign first = first_q;

  // R11
  restart_reenter_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (st_q == ST_RST && slot_q == 2'd0));

  // R5
  slot_order_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MRS && $past(st_q) == ST_MRS && slot_q != $past(slot_q))
      |-> slot_q == $past(slot_q) + 2'd1);

endmodule

// File: rtl/ddr3_init_out.sv
module ddr3_init_out
  import ddr3_init_pkg::*;
#(
  parameter int   ADDR_W   = 15,
  parameter logic ODT_IDLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  init_st_e          state,
  input  logic [1:0]        slot,
  input  logic              first,
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  input  logic [ADDR_W-1:0] mr3,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [2:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  init_cmd_e         cmd;
  logic [1:0]        mr_num;
  logic [ADDR_W-1:0] payload;
  logic [ADDR_W-1:0] addr_d;
  logic [2:0]        ba_d;
  logic              odt_lvl;

  always_comb begin
    cmd = CMD_DES;
    if (first && state == ST_MRS) cmd = CMD_MRS;
    if (first && state == ST_ZQ)  cmd = CMD_ZQCL;
  end

  assign mr_num = slot_to_mr(slot);

  always_comb begin
    case (mr_num)
      2'd0:    payload = mr0;
      2'd1:    payload = mr1;
      2'd2:    payload = mr2;
      default: payload = mr3;
    endcase
  end

  always_comb begin
    addr_d = '0;
    ba_d   = 3'd0;
    case (cmd)
      CMD_MRS: begin
        addr_d = payload;
        ba_d   = {1'b0, mr_num};
      end
      CMD_ZQCL: addr_d[ZQ_ADDR_BIT] = 1'b1;
      default: ;
    endcase
  end

  // nominal termination enabled -> termination pin must stay low
  assign odt_lvl = (mr1[2] | mr1[6] | mr1[9]) ? 1'b0 : ODT_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ddr_reset_n <= 1'b0;
      ddr_cke     <= 1'b0;
      ddr_odt     <= 1'b0;
      ddr_cs_n    <= 1'b1;
      ddr_ras_n   <= 1'b1;
      ddr_cas_n   <= 1'b1;
      ddr_we_n    <= 1'b1;
      ddr_ba      <= 3'd0;
      ddr_addr    <= '0;
      init_done   <= 1'b0;
    end else begin
      ddr_reset_n <= (state != ST_RST);
      ddr_cke     <= (state != ST_RST) && (state != ST_STAB);
      if (state == ST_RST) ddr_odt <= odt_lvl;
      ddr_cs_n    <= (cmd == CMD_DES);
      ddr_ras_n   <= (cmd != CMD_MRS);
      ddr_cas_n   <= (cmd != CMD_MRS);
      ddr_we_n    <= (cmd == CMD_DES);
      ddr_ba      <= ba_d;
      ddr_addr    <= addr_d;
      init_done   <= (state == ST_DONE);
    end
  end

  // R10
  odt_static_chk: assert property (@(posedge clk) disable iff (rst)
    (ddr_reset_n && $past(ddr_reset_n)) |-> $stable(ddr_odt));

  // R7
  zq_a10_chk: assert property (@(posedge clk) disable iff (rst)
    (!ddr_cs_n && ddr_ras_n && ddr_cas_n && !ddr_we_n) |-> ddr_addr[ZQ_ADDR_BIT]);

  // R2
  cke_low_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !ddr_reset_n |-> !ddr_cke);

endmodule

// File: rtl/ddr3_rst_seq.sv
module ddr3_rst_seq
  import ddr3_init_pkg::*;
#(
  parameter int   CLK_PS     = 2500,
  parameter int   RESET_NS   = 100,
  parameter int   CKE_SU_NS  = 10,
  parameter int   STAB_NS    = 500000,
  parameter int   XPR_NS     = 170,
  parameter int   MRD_CYC    = 4,
  parameter int   MOD_CYC    = 12,
  parameter int   ZQINIT_CYC = 512,
  parameter int   ADDR_W     = 15,
  parameter logic ODT_IDLE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  input  logic [ADDR_W-1:0] mr3,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [2:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  localparam int SU_CYC   = imax(ns_to_cyc(CKE_SU_NS, CLK_PS), 1);
  localparam int RST_CYC  = imax(imax(ns_to_cyc(RESET_NS, CLK_PS), SU_CYC), 1);
  localparam int STAB_CYC = imax(ns_to_cyc(STAB_NS, CLK_PS), 1);
  localparam int XPR_CYC  = imax(ns_to_cyc(XPR_NS, CLK_PS), 5);
  localparam int MAX_CYC  = imax(imax(imax(RST_CYC, STAB_CYC), imax(XPR_CYC, ZQINIT_CYC)),
                                 imax(MRD_CYC, MOD_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  init_st_e         state;
  logic [1:0]       slot;
  logic             first;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             tmr_zero;

  ddr3_init_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (RST_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .zero     (tmr_zero)
  );

  ddr3_init_fsm #(
    .CNT_W      (CNT_W),
    .RST_CYC    (RST_CYC),
    .STAB_CYC   (STAB_CYC),
    .XPR_CYC    (XPR_CYC),
    .MRD_CYC    (MRD_CYC),
    .MOD_CYC    (MOD_CYC),
    .ZQINIT_CYC (ZQINIT_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .tmr_zero (tmr_zero),
    .state    (state),
    .slot     (slot),
    .first    (first),
    .load     (load),
    .load_val (load_val)
  );

  ddr3_init_out #(
    .ADDR_W   (ADDR_W),
    .ODT_IDLE (ODT_IDLE)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .slot        (slot),
    .first       (first),
    .mr0         (mr0),
    .mr1         (mr1),
    .mr2         (mr2),
    .mr3         (mr3),
    .ddr_reset_n (ddr_reset_n),
    .ddr_cke     (ddr_cke),
    .ddr_odt     (ddr_odt),
    .ddr_cs_n    (ddr_cs_n),
    .ddr_ras_n   (ddr_ras_n),
    .ddr_cas_n   (ddr_cas_n),
    .ddr_we_n    (ddr_we_n),
    .ddr_ba      (ddr_ba),
    .ddr_addr    (ddr_addr),
    .init_done   (init_done)
  );

  // ---------------- timing checkers on the pins ----------------
  localparam int CW  = $clog2(MAX_CYC + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_CYC + 1);

  logic          is_mrs, is_zq;
  logic [CW-1:0] cke_lo_q, rn_hi_q, since_cmd_q;

  assign is_mrs = !ddr_cs_n && !ddr_ras_n && !ddr_cas_n && !ddr_we_n;
  assign is_zq  = !ddr_cs_n && ddr_ras_n && ddr_cas_n && !ddr_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_lo_q    <= '0;
      rn_hi_q     <= '0;
      since_cmd_q <= SAT;
    end else begin
      cke_lo_q    <= ddr_cke ? '0 : ((cke_lo_q == SAT) ? SAT : cke_lo_q + 1'b1);
      rn_hi_q     <= !ddr_reset_n ? '0 : ((rn_hi_q == SAT) ? SAT : rn_hi_q + 1'b1);
      if (!ddr_reset_n)             since_cmd_q <= SAT;
      else if (is_mrs || is_zq)     since_cmd_q <= CW'(1);
      else if (since_cmd_q != SAT)  since_cmd_q <= since_cmd_q + 1'b1;
    end
  end

  // R2
  cke_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ddr_reset_n) |-> cke_lo_q >= CW'(SU_CYC));

  // R3
  stab_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ddr_cke) |-> rn_hi_q >= CW'(STAB_CYC));

  // R6
  mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> since_cmd_q >= CW'(MRD_CYC));

  // R7
  mod_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_zq |-> since_cmd_q >= CW'(MOD_CYC));

  // R5
  mrs_cke_chk: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (ddr_cke && ddr_reset_n && !init_done));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (ddr_reset_n && ddr_cke && ddr_cs_n));

  // R11
  done_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_done) |-> !ddr_reset_n);

endmodule

// File: tb/ddr3_rst_seq_bench.sv
`timescale 1ns/1ps
module ddr3_rst_seq_bench;

  localparam int CLK_PS = 4000;
  localparam int RESET_NS = 100, CKE_SU_NS = 10, STAB_NS = 2000, XPR_NS = 170;
  localparam int MRD = 4, MODC = 12, ZQI = 64, AW = 15;

  function automatic int cdiv(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  // expected cycle counts, from the requirement formulas
  int e_rst, e_stab, e_xpr;

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0;
  logic [AW-1:0] mr0, mr1, mr2, mr3;
  logic ddr_reset_n, ddr_cke, ddr_odt, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
  logic [2:0] ddr_ba;
  logic [AW-1:0] ddr_addr;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ddr3_rst_seq #(
    .CLK_PS(CLK_PS), .RESET_NS(RESET_NS), .CKE_SU_NS(CKE_SU_NS), .STAB_NS(STAB_NS),
    .XPR_NS(XPR_NS), .MRD_CYC(MRD), .MOD_CYC(MODC), .ZQINIT_CYC(ZQI),
    .ADDR_W(AW), .ODT_IDLE(1'b1)
  ) u_ddr3_rst_seq (
    .clk(clk), .rst(rst), .restart(restart),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3),
    .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_odt(ddr_odt),
    .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Observe one full run from reset release; first sample is one edge after release.
  task automatic observe(input bit exp_odt, output bit first_rn, output bit first_done);
    int t_rn = -1, t_cke = -1, t_done = -1, lo_cnt = 0, cke_viol = 0;
    int ncmd = 0, odt_bad = 0, done_drop = 0, late_cmd = 0;
    int c_t[8], c_ba[8], c_addr[8], c_kind[8];
    int exp_ba[4] = '{2, 3, 1, 0};
    int exp_addr[4];
    exp_addr = '{int'(mr2), int'(mr3), int'(mr1), int'(mr0)};
    first_rn = 1'b1; first_done = 1'b1;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      if (t == 0) begin first_rn = ddr_reset_n; first_done = init_done; end
      if (!ddr_reset_n) begin
        if (t_rn < 0) lo_cnt++;
        if (ddr_cke) cke_viol++;
      end
      if (ddr_reset_n && t_rn < 0) t_rn = t;
      if (ddr_cke && t_cke < 0) t_cke = t;
      if (ddr_reset_n && ddr_odt != exp_odt) odt_bad++;
      if (!ddr_cs_n) begin
        if (t_done >= 0) late_cmd++;
        if (ncmd < 8) begin
          c_t[ncmd] = t; c_ba[ncmd] = int'(ddr_ba); c_addr[ncmd] = int'(ddr_addr);
          c_kind[ncmd] = ({ddr_ras_n, ddr_cas_n, ddr_we_n} == 3'b000) ? 1 :
                         ({ddr_ras_n, ddr_cas_n, ddr_we_n} == 3'b110) ? 2 : 3;
        end
        ncmd++;
      end
      if (init_done && t_done < 0) t_done = t;
      if (t_done >= 0 && !init_done) done_drop++;
      if (t_done >= 0 && t >= t_done + 16) break;
    end
    chk("R2 reset_n low cycles", lo_cnt, e_rst);
    chk("R2 cke high while reset_n low", cke_viol, 0);
    chk("R3 reset_n rise to cke rise", t_cke - t_rn, e_stab);
    chk("R9 command count", ncmd, 5);
    chk("R10 odt level/static", odt_bad, 0);
    if (ncmd >= 5) begin
      chk("R4 cke rise to first MRS", c_t[0] - t_cke, e_xpr);
      for (int i = 0; i < 4; i++) begin
        chk("R5 MRS encoding", c_kind[i], 1);
        chk("R5 MRS bank", c_ba[i], exp_ba[i]);
        chk("R5 MRS payload", c_addr[i], exp_addr[i]);
      end
      for (int i = 1; i < 4; i++) chk("R6 MRS spacing", c_t[i] - c_t[i-1], MRD);
      chk("R7 ZQCL encoding", c_kind[4], 2);
      chk("R7 ZQCL address", c_addr[4], 1 << 10);
      chk("R7 ZQCL bank", c_ba[4], 0);
      chk("R7 MR0 to ZQCL", c_t[4] - c_t[3], MODC);
      chk("R8 ZQCL to done", t_done - c_t[4], ZQI);
    end
    chk("R8 done held", done_drop, 0);
    chk("R8 no command after done", late_cmd, 0);
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic t_reset_and_first_run();
    bit frn, fdn;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset_n in reset", ddr_reset_n, 0);
    chk("R1 cke in reset", ddr_cke, 0);
    chk("R1 cs_n in reset", ddr_cs_n, 1);
    chk("R1 done in reset", init_done, 0);
    rst = 1'b0;
    observe(1'b1, frn, fdn);   // R10: RTT field clear -> idle level 1
  endtask

  task automatic t_restart_after_done();
    bit frn, fdn;
    mr1 = 15'h0044;            // R10: bits 2 and 6 set -> odt 0
    pulse_restart();
    observe(1'b0, frn, fdn);
    chk("R11 reset_n after restart", frn, 0);
    chk("R11 done cleared", fdn, 0);
  endtask

  task automatic t_restart_mid_mrs();
    bit frn, fdn;
    mr0 = 15'h1B50; mr1 = 15'h0200; mr2 = 15'h0008; mr3 = 15'h0003;
    pulse_restart();
    for (int i = 0; i < 2000 && ddr_cs_n; i++) @(negedge clk);
    repeat (5) @(negedge clk);   // now between the MR3 and MR1 writes
    pulse_restart();
    observe(1'b0, frn, fdn);     // R11: full replay; bit 9 -> odt 0
    chk("R11 reset_n after mid restart", frn, 0);
  endtask

  initial begin
    e_rst  = (cdiv(RESET_NS) > cdiv(CKE_SU_NS)) ? cdiv(RESET_NS) : cdiv(CKE_SU_NS);
    e_stab = cdiv(STAB_NS);
    e_xpr  = (cdiv(XPR_NS) > 5) ? cdiv(XPR_NS) : 5;
    mr0 = 15'h0D70; mr1 = 15'h0011; mr2 = 15'h0018; mr3 = 15'h0004;
    t_reset_and_first_run();
    t_restart_after_done();
    t_restart_mid_mrs();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule